// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

This block is a 16-bit up-counter that advances on a slow tick enable (nominally 32.768 kHz) divided by a power-of-two prescaler. Two compare registers are watched while the counter runs. When a counting step lands the counter on a compare value, a sticky match flag is raised for that compare. A per-compare event-mode field decides whether that flag drives the level interrupt output.

Software reaches the timer through a small word-wide register port with four locations: the counter, compare 1, compare 2 and a combined setup/status word. The setup word holds the enable, the scale, the two event modes, a written-since-reset indicator and the two match flags. The flags are cleared by writing one to them. A single setup write can therefore stop the counter and acknowledge both events.

For a periodic or one-shot event, software loads compare 2 with the delta and clears the counter. It then writes the enable bit, the compare-2 flag bit and the interrupt mode. The block carries no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal, and a write takes effect on the clock edge where `reg_wr` is high.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, both compare registers and the setup word read 0, and `irq` is low.
- R2: Register addresses are 0 = counter, 1 = compare 1, 2 = compare 2 and 3 = setup. The read data is combinational from `reg_addr`. Setup bits [7:4] read as 0 and ignore writes.
- R3: The scale field sits in setup [3:0]. While enabled, the counter advances once every 2^scale `tick_en` pulses, with the first advance on the 2^scale-th pulse after enabling. Scale values from 9 to 15 act as 8.
- R4: The enable bit is setup bit 15. While it is 0 the counter holds its value and the prescaler phase returns to zero.
- R5: The compare-1 flag is setup bit 13 and the compare-2 flag is setup bit 14. A flag is set when a counting step makes the counter equal to its compare value. A direct counter write never sets a flag.
- R6: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a match and a clear arrive in the same cycle, the match wins.
- R7: The compare-2 event mode sits in setup [9:8] and the compare-1 event mode in [11:10]. `irq` is high exactly when some flag is set and its mode equals 3.
- R8: The counter keeps counting after a match and wraps from 0xFFFF to 0x0000.
- R9: A counter write takes priority over a counting step in the same cycle.
- R10: Setup bit 12 is a read-only indicator. It reads 0 after reset and reads 1 from the first setup write onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse from the slow timebase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The checker assumes that `reg_addr` and `reg_wdata` are only meaningful while `reg_wr` is high. It also assumes that `tick_en` is a single-cycle pulse, so at most one counting step occurs per clock. The stimulus changes inputs only on the falling clock edge and drops each strobe after one cycle. It leaves idle cycles between tick pulses, and the only case where a tick and a write share a cycle is the directed collision tests. The properties therefore see only legal single-step counting, and a counter value can change only through a write or an increment by one.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W     = 16;
  localparam int NCMP      = 2;
  localparam int SCALE_W   = 4;
  localparam int SCALE_MAX = 8;
  localparam int PRE_W     = SCALE_MAX;

  localparam logic [1:0] A_CNT   = 2'd0;
  localparam logic [1:0] A_CMP1  = 2'd1;
  localparam logic [1:0] A_CMP2  = 2'd2;
  localparam logic [1:0] A_SETUP = 2'd3;

  localparam int B_MODE2 = 8;   // [9:8]
  localparam int B_MODE1 = 10;  // [11:10]
  localparam int B_IND   = 12;
  localparam int B_FLAG1 = 13;
  localparam int B_FLAG2 = 14;
  localparam int B_EN    = 15;

  typedef logic [1:0] evt_mode_t;
  localparam evt_mode_t MODE_IRQ = 2'b11;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler
  import evt_timer_pkg::*;
#(
  parameter int SW   = SCALE_W,
  parameter int SMAX = SCALE_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic [SW-1:0] scale,
  output logic          step
);
  localparam int PW = SMAX;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] mask;
  int            eff;

  always_comb begin
    eff  = (int'(scale) > SMAX) ? SMAX : int'(scale);
    mask = PW'((1 << eff) - 1);
  end

  assign step = tick_en && run && ((phase_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase_q <= '0;
    else if (tick_en)   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/evt_match.sv
module evt_match
  import evt_timer_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int N = NCMP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  cnt_wr,
  input  logic [W-1:0]          cnt,
  input  logic [N-1:0][W-1:0]   cmp,
  input  logic [N-1:0]          clr,
  input  evt_mode_t [N-1:0]     mode,
  output logic [N-1:0]          flag,
  output logic                  irq
);
  logic [W-1:0] cnt_inc;
  logic [N-1:0] hit;
  assign cnt_inc = cnt + 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = step && !cnt_wr && (cnt_inc == cmp[i]);
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (hit[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < N; i++)
      if (flag[i] && mode[i] == MODE_IRQ) irq = 1'b1;
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic [CNT_W-1:0]            cnt_q;
  logic [NCMP-1:0][CNT_W-1:0]  cmp_q;
  logic                        en_q;
  logic                        ind_q;
  logic [SCALE_W-1:0]          scale_q;
  evt_mode_t [NCMP-1:0]        mode_q;
  logic [NCMP-1:0]             flag_q;
  logic [NCMP-1:0]             clr;
  logic                        step;
  logic                        wr_cnt, wr_setup;

  assign wr_cnt   = reg_wr && reg_addr == A_CNT;
  assign wr_setup = reg_wr && reg_addr == A_SETUP;
  assign clr      = wr_setup ? {reg_wdata[B_FLAG2], reg_wdata[B_FLAG1]} : '0;

  evt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(en_q),
    .scale(scale_q), .step(step)
  );

  evt_match u_match (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_wr(wr_cnt), .cnt(cnt_q),
    .cmp(cmp_q), .clr(clr), .mode(mode_q), .flag(flag_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= reg_wdata;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      en_q    <= 1'b0;
      ind_q   <= 1'b0;
      scale_q <= '0;
      mode_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CMP1:  cmp_q[0] <= reg_wdata;
        A_CMP2:  cmp_q[1] <= reg_wdata;
        A_SETUP: begin
          en_q      <= reg_wdata[B_EN];
          ind_q     <= 1'b1;
          scale_q   <= reg_wdata[SCALE_W-1:0];
          mode_q[1] <= reg_wdata[B_MODE2+:2];
          mode_q[0] <= reg_wdata[B_MODE1+:2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT:  reg_rdata = cnt_q;
      A_CMP1: reg_rdata = cmp_q[0];
      A_CMP2: reg_rdata = cmp_q[1];
      default: begin
        reg_rdata[SCALE_W-1:0]  = scale_q;
        reg_rdata[B_MODE2+:2]   = mode_q[1];
        reg_rdata[B_MODE1+:2]   = mode_q[0];
        reg_rdata[B_IND]        = ind_q;
        reg_rdata[B_FLAG1]      = flag_q[0];
        reg_rdata[B_FLAG2]      = flag_q[1];
        reg_rdata[B_EN]         = en_q;
      end
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp2,
  input logic [NCMP-1:0]  flag,
  input logic             ind,
  input logic             en,
  input logic             irq
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  logic wr_cnt, wr_setup, any_wr;
  assign wr_cnt   = reg_wr && reg_addr == A_CNT;
  assign wr_setup = reg_wr && reg_addr == A_SETUP;
  assign any_wr   = reg_wr;

  // R4: disabled counter does not move
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (!en && !wr_cnt) |=> $stable(cnt));

  // R3 / R8: counter moves by at most one step without a write
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R6: a flag stays set unless cleared by a one
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (flag[1] && !(wr_setup && reg_wdata[B_FLAG2])) |=> flag[1]);

  // R5: compare-2 flag rises only where the counter landed on compare 2
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($rose(flag[1]) && !$past(any_wr)) |-> (cnt == cmp2));

  // R7: no interrupt without a pending flag
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (flag == '0) |-> !irq);

  // R10: indicator never drops outside reset
  assert_ind_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ind |=> ind);
endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt(cnt_q), .cmp2(cmp_q[1]), .flag(flag_q),
  .ind(ind_q), .en(en_q), .irq(irq)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read+check, 2 tick pulses
    logic [1:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd3, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 setup
    '{2'd1, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 counter
    '{2'd0, 2'd2, 16'h0005, 16'h0000, 1'b0, 4'd2},  // R2
    '{2'd1, 2'd2, 16'h0000, 16'h0005, 1'b0, 4'd2},
    '{2'd0, 2'd1, 16'h0003, 16'h0000, 1'b0, 4'd2},
    '{2'd1, 2'd1, 16'h0000, 16'h0003, 1'b0, 4'd2},
    '{2'd0, 2'd3, 16'h83F0, 16'h0000, 1'b0, 4'd10}, // R10, R2 reserved bits
    '{2'd1, 2'd3, 16'h0000, 16'h9300, 1'b0, 4'd10},
    '{2'd2, 2'd0, 16'd3,    16'h0000, 1'b0, 4'd5},
    '{2'd1, 2'd0, 16'h0000, 16'h0003, 1'b0, 4'd3},  // R3 scale 0
    '{2'd1, 2'd3, 16'h0000, 16'hB300, 1'b0, 4'd5},  // R5 flag1, R7 mode off
    '{2'd2, 2'd0, 16'd2,    16'h0000, 1'b0, 4'd5},
    '{2'd1, 2'd3, 16'h0000, 16'hF300, 1'b1, 4'd7},  // R7 irq on cmp2
    '{2'd0, 2'd3, 16'hA300, 16'h0000, 1'b0, 4'd6},
    '{2'd1, 2'd3, 16'h0000, 16'hD300, 1'b1, 4'd6},  // R6 zero keeps flag2
    '{2'd0, 2'd3, 16'h4300, 16'h0000, 1'b0, 4'd6},
    '{2'd1, 2'd3, 16'h0000, 16'h1300, 1'b0, 4'd6},  // R6 cleared, irq low
    '{2'd2, 2'd0, 16'd4,    16'h0000, 1'b0, 4'd4},
    '{2'd1, 2'd0, 16'h0000, 16'h0005, 1'b0, 4'd4},  // R4 hold
    '{2'd0, 2'd0, 16'hFFFE, 16'h0000, 1'b0, 4'd9},
    '{2'd1, 2'd0, 16'h0000, 16'hFFFE, 1'b0, 4'd9},
    '{2'd0, 2'd3, 16'h8000, 16'h0000, 1'b0, 4'd8},
    '{2'd2, 2'd0, 16'd2,    16'h0000, 1'b0, 4'd8},
    '{2'd1, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 wrap
    '{2'd2, 2'd0, 16'd3,    16'h0000, 1'b0, 4'd8},
    '{2'd1, 2'd3, 16'h0000, 16'hB000, 1'b0, 4'd7},  // R7 flag1 mode 0
    '{2'd0, 2'd3, 16'hAC00, 16'h0000, 1'b0, 4'd6},
    '{2'd1, 2'd3, 16'h0000, 16'h9C00, 1'b0, 4'd6},
    '{2'd0, 2'd0, 16'h0003, 16'h0000, 1'b0, 4'd5},
    '{2'd1, 2'd3, 16'h0000, 16'h9C00, 1'b0, 4'd5},  // R5 write no flag
    '{2'd0, 2'd0, 16'h0002, 16'h0000, 1'b0, 4'd7},
    '{2'd2, 2'd0, 16'd1,    16'h0000, 1'b0, 4'd7},
    '{2'd1, 2'd3, 16'h0000, 16'hBC00, 1'b1, 4'd7},  // R7 irq on cmp1
    '{2'd0, 2'd3, 16'h6002, 16'h0000, 1'b0, 4'd3},
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd3},
    '{2'd0, 2'd3, 16'h8002, 16'h0000, 1'b0, 4'd3},
    '{2'd2, 2'd0, 16'd3,    16'h0000, 1'b0, 4'd3},
    '{2'd1, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd3},  // R3 scale 2 not yet
    '{2'd2, 2'd0, 16'd1,    16'h0000, 1'b0, 4'd3},
    '{2'd1, 2'd0, 16'h0000, 16'h0001, 1'b0, 4'd3},  // R3 4th tick
    '{2'd0, 2'd3, 16'h000C, 16'h0000, 1'b0, 4'd3},
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'd3},
    '{2'd0, 2'd3, 16'h800C, 16'h0000, 1'b0, 4'd3},
    '{2'd2, 2'd0, 16'd255,  16'h0000, 1'b0, 4'd3}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input logic ai, input logic ei, input int req);
    checks++;
    if (act !== exp || ai !== ei) begin
      fails++;
      $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b", req, act, ai, exp, ei);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick_en = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input logic ei, input int req);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(reg_rdata, exp, irq, ei, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data, 1'b0);
        2'd1: rd(VEC[i].addr, VEC[i].exp, VEC[i].eirq, int'(VEC[i].req));
        default: ticks(int'(VEC[i].data));
      endcase
    end
    // R3: scale 12 acts as 8, first step on the 256th pulse
    rd(2'd0, 16'h0000, 1'b0, 3);
    ticks(1);
    rd(2'd0, 16'h0001, 1'b0, 3);
    rd(2'd3, 16'h900C, 1'b0, 3);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(2'd3, 16'h0000, 1'b0, 1);
    rd(2'd0, 16'h0000, 1'b0, 1);
    rd(2'd2, 16'h0000, 1'b0, 1);

    // R6: match and clear in the same cycle, match wins
    wr(2'd2, 16'h0001, 1'b0);
    wr(2'd3, 16'h8000, 1'b0);
    wr(2'd3, 16'hC000, 1'b1);
    rd(2'd3, 16'hD000, 1'b0, 6);

    // R9: counter write beats a counting step
    wr(2'd0, 16'h0100, 1'b1);
    rd(2'd0, 16'h0100, 1'b0, 9);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule